// File: doc/BRIEF.md
# Burst Address Counter

This block produces the address that one port of a synchronous dual-port memory uses for each clocked access. A port can present a fresh address on its external bus for every access. It can also supply one start address and let the block generate the rest of a burst, so that consecutive reads or writes follow without further addressing from outside. The block does not look at the access direction: a write burst advances the address exactly like a read burst.

Three active-low controls select what happens in each cycle. They are taken in strict priority order: clear, then load, then step, then hold. The block computes the address for the current cycle's access from these controls, the external bus and the stored address. The memory core uses that address in the same cycle, and the block stores it at the rising clock edge as the base for the next cycle. Because of this, a clear or a load costs no dead cycle: the access in that very cycle already goes to the new address.

The address width is a parameter that matches the depth of the memory. Both the address used for the current access and the stored address are brought out as ports. The block has no data path of its own, so every pin is a plain control or status pin.

Top module: `burst_addr_ctr`

## Requirements
- R1: While rst_n is low, held_addr is 0. In the first cycle after release, with all three controls high, access_addr is 0.
- R2: When zero_n is low, access_addr is 0 in that same cycle, whatever strobe_n, advance_n and ext_addr are. After the rising edge, held_addr is 0.
- R3: When zero_n is high and strobe_n is low, access_addr equals ext_addr in that same cycle, whatever advance_n is.
- R4: When zero_n and strobe_n are high and advance_n is low, access_addr equals held_addr plus one.
- R5: When zero_n, strobe_n and advance_n are all high, access_addr equals held_addr. Repeated cycles therefore keep addressing the same location.
- R6: A step from the all-ones address wraps access_addr to 0, modulo 2^ADDR_W.
- R7: At each rising clock edge with rst_n high, held_addr takes the value that access_addr had in the cycle just ended. It changes at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; all controls are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the stored address |
| ext_addr | input | ADDR_W | Address supplied from outside for a load |
| strobe_n | input | 1 | Active-low load of ext_addr |
| advance_n | input | 1 | Active-low step of the address by one |
| zero_n | input | 1 | Active-low clear of the address to 0 (highest priority) |
| access_addr | output | ADDR_W | Address used by this cycle's access |
| held_addr | output | ADDR_W | Address stored at the last rising edge |

## Verification
The assertions assume that the three controls and ext_addr are settled, with no X or Z, at every rising edge while rst_n is high. They also assume that rst_n is released away from a clock edge. The bench changes every input only just after a falling edge, holds it steady through the next rising edge, and releases reset on a falling edge. A predicted address is therefore always compared against stable inputs. The stimulus mixes directed priority conflicts, including the wrap at the top of the address space, with a long run of pseudo-random control combinations.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } addr_op_e;

endpackage

// File: rtl/burst_addr_decode.sv
module burst_addr_decode
  import burst_addr_pkg::*;
(
  input  logic     zero_n,
  input  logic     strobe_n,
  input  logic     advance_n,
  output addr_op_e op
);

  // fixed priority: clear, load, step, hold
  always_comb begin
    if (!zero_n)         op = OP_CLEAR;
    else if (!strobe_n)  op = OP_LOAD;
    else if (!advance_n) op = OP_STEP;
    else                 op = OP_HOLD;
  end

endmodule

// File: rtl/burst_addr_next.sv
module burst_addr_next
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  addr_op_e          op,
  input  logic [ADDR_W-1:0] held,
  input  logic [ADDR_W-1:0] ext,
  output logic [ADDR_W-1:0] next_addr
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] stepped;

  // modulo-2^ADDR_W increment; the carry out is dropped, giving the wrap
  assign stepped = held + ONE;

  always_comb begin
    unique case (op)
      OP_CLEAR: next_addr = '0;
      OP_LOAD:  next_addr = ext;
      OP_STEP:  next_addr = stepped;
      default:  next_addr = held;
    endcase
  end

endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  // R7: stored value follows the previous cycle's access address
  p_store_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> q == $past(d));

endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              strobe_n,
  input  logic              advance_n,
  input  logic              zero_n,
  output logic [ADDR_W-1:0] access_addr,
  output logic [ADDR_W-1:0] held_addr
);

  addr_op_e op;

  burst_addr_decode u_decode (
    .zero_n    (zero_n),
    .strobe_n  (strobe_n),
    .advance_n (advance_n),
    .op        (op)
  );

  burst_addr_next #(.ADDR_W(ADDR_W)) u_next (
    .op        (op),
    .held      (held_addr),
    .ext       (ext_addr),
    .next_addr (access_addr)
  );

  burst_addr_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (access_addr),
    .q     (held_addr)
  );

  // R2: clear wins over everything, in the same cycle
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_n |-> access_addr == '0);

  // R2: stored address is zero after a clear cycle
  p_clear_stored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_n |=> held_addr == '0);

  // R3: load uses the external bus in the same cycle
  p_load_used_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n && !strobe_n) |-> access_addr == ext_addr);

  // R4, R6: step is previous address plus one, modulo the address space
  p_step_plus_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n && strobe_n && !advance_n) |-> access_addr == ADDR_W'(held_addr + 1'b1));

  // R5: hold repeats the stored address
  p_hold_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n && strobe_n && advance_n) |-> access_addr == held_addr);

  // R1: reset state
  always_comb begin
    if (!rst_n) a_reset_zero_r1: assert (held_addr == '0);
  end

endmodule

// File: tb/test_burst_addr_ctr.sv
`timescale 1ns/1ps
module test_burst_addr_ctr;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          strobe_n = 1'b1;
  logic          advance_n = 1'b1;
  logic          zero_n = 1'b1;
  logic [AW-1:0] access_addr;
  logic [AW-1:0] held_addr;

  always #4 clk = ~clk;

  burst_addr_ctr #(.ADDR_W(AW)) i_burst_addr_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_addr    (ext_addr),
    .strobe_n    (strobe_n),
    .advance_n   (advance_n),
    .zero_n      (zero_n),
    .access_addr (access_addr),
    .held_addr   (held_addr)
  );

  typedef struct {
    logic [AW-1:0] exp_acc;
    logic [AW-1:0] exp_held;
    string         tag;
  } item_t;

  item_t         sb_q[$];
  int            n_checks = 0;
  int            n_fail = 0;
  logic [AW-1:0] mdl_held = '0;
  bit            done = 1'b0;

  task automatic check(input string tag, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of controls and predict the outcome
  task automatic drive(input bit z, input bit s, input bit a,
                       input logic [AW-1:0] ext, input string tag);
    item_t it;
    @(negedge clk);
    zero_n = z; strobe_n = s; advance_n = a; ext_addr = ext;
    it.exp_held = mdl_held;
    if (!z)      it.exp_acc = '0;
    else if (!s) it.exp_acc = ext;
    else if (!a) it.exp_acc = mdl_held + AW'(1);
    else         it.exp_acc = mdl_held;
    it.tag = tag;
    sb_q.push_back(it);
    mdl_held = it.exp_acc;   // R7: stored at the coming edge
  endtask

  // monitor: compare shortly after inputs settle, well before the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, "access_addr", access_addr, it.exp_acc);
        check({it.tag, "/R7"}, "held_addr", held_addr, it.exp_held);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "held_addr in reset", held_addr, '0);
    rst_n = 1'b1;
    drive(1, 1, 1, 16'hAAAA, "R1");            // idle after reset: address 0
    drive(1, 0, 1, 16'h1234, "R3");            // load
    drive(1, 1, 0, 16'h0000, "R4");            // 1235
    drive(1, 1, 0, 16'hFFFF, "R4");            // 1236
    drive(1, 1, 1, 16'h0F0F, "R5");            // hold
    drive(1, 1, 1, 16'h0F0F, "R5");
    drive(1, 0, 0, 16'h4000, "R3");            // load wins over step
    drive(0, 0, 0, 16'h5555, "R2");            // clear wins over all
    drive(1, 1, 1, 16'h5555, "R2");            // stored value now 0
    drive(1, 1, 0, 16'h0000, "R4");            // 1
    drive(1, 0, 1, 16'hFFFE, "R3");
    drive(1, 1, 0, 16'h0000, "R4");            // FFFF
    drive(1, 1, 0, 16'h0000, "R6");            // wraps to 0
    drive(1, 1, 0, 16'h0000, "R6");            // 1
    drive(0, 1, 1, 16'h0000, "R2");            // clear alone
    drive(1, 0, 1, 16'hFFFF, "R3");
    drive(1, 1, 1, 16'h0000, "R5");
    drive(1, 1, 0, 16'h0000, "R6");
    for (int i = 0; i < 400; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      drive(r[0] | r[3], r[1], r[2], AW'($urandom), "R7");
    end
    @(negedge clk);
    #3;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule